// File: doc/BRIEF.md
# Six-Pin Configurable GPIO Port

This block is the general-purpose I/O port of a small 8-bit microcontroller. Software reaches it over a plain register bus made of an address, write data, a write strobe and combinational read data. Three registers are visible. The output-value register and the direction register hold five bits each, one per low pin. The pin-sample register returns the synchronized state of all six pads.

Pins 0 to 4 can drive in both directions. Each of them has a pull-up that switches on when the pin is an input and its output-value bit is 1. Pin 5 can only read or pull low, and the port registers give it no output control, so in practice the port never drives it.

Two static configuration inputs describe the device's reset and clock choices. They take pins 3, 4 and 5 away from the port when those functions need them. A taken pin is released to high impedance and reads as 0. While reset is asserted, every pad is released at once, with no clock edge needed.

Top module: `gpio6_port`

## Requirements
- R1: The output-value register is at address 0x18 and the direction register at 0x17. Both hold bits 4..0 and read back with bits 7..5 as 0, and writes to bits 7..5 are ignored. The pin-sample register is at 0x16 and returns the pads in bits 5..0 with bits 7..6 as 0. Any other address reads 0.
- R2: For pins 0 to 4, a direction bit of 1 drives the pad (pad_oe=1) with the output-value bit on pad_out. A direction bit of 0 leaves the pad undriven, and the pull-up is on exactly when the output-value bit is 1. A pad never has its driver and its pull-up on together.
- R3: Pin 5 never drives high and never gets a pull-up: pad_oe[5], pad_out[5] and pad_pullup[5] stay 0.
- R4: While rst_n is low, all pad_oe and pad_pullup bits are 0. This takes effect asynchronously, without waiting for a clock edge.
- R5: Reset clears the output-value and direction registers to 0.
- R6: When cfg_ext_reset is 1, pin 5 belongs to the reset function and reads 0 in the pin-sample register. When it is 0, pin 5 is a port input.
- R7: cfg_clk_sel encodes the clock source. 0 is the internal RC oscillator, which takes no pin. 1 (external RC) and 2 (external clock) take pin 3. 3 (crystal), 4 (low-frequency crystal) and 5 (ceramic resonator) take pins 3 and 4. The reserved codes 6 and 7 also take pins 3 and 4.
- R8: A pin taken by a clock or reset function is undriven, has no pull-up, and reads 0, whatever the port registers hold.
- R9: Every pad input passes through two flip-flops. A change applied between clock edges shows up in the pin-sample register after the second rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_reset | input | 1 | 1 when pin 5 serves as the external reset |
| cfg_clk_sel | input | 3 | Static clock-source option code |
| bus_addr | input | 6 | I/O register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 6 | Raw pad levels |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables |
| pad_pullup | output | 6 | Pad pull-up enables |

## Verification
The bench drops reset between clock edges and checks the pads a fraction of a cycle later. A design that releases its pads only on a clock edge would still be driving at that point. Each clock option is stepped through with every pad driven or pulled up, and with all inputs high. A wrong ownership decode shows up as a driver or pull-up left on a crystal pin, or as a stray 1 read from a taken pin. Writes of 0xFF test that the unimplemented upper bits read back as 0. The synchronizer is sampled one edge after an input change and again one edge later. A single-flop path, or a three-flop path, misses one of those two samples.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;

   typedef enum logic [2:0] {
      CK_INT_RC    = 3'd0,
      CK_EXT_RC    = 3'd1,
      CK_EXT_CLK   = 3'd2,
      CK_XTAL      = 3'd3,
      CK_LF_XTAL   = 3'd4,
      CK_RESONATOR = 3'd5
   } clk_opt_e;

   localparam int unsigned PORT_ADDR_W = 6;
   localparam int unsigned PORT_DATA_W = 8;
   localparam int unsigned PORT_PINS   = 6;

   localparam logic [PORT_ADDR_W-1:0] ADDR_OUTVAL = 6'h18;
   localparam logic [PORT_ADDR_W-1:0] ADDR_DIR    = 6'h17;
   localparam logic [PORT_ADDR_W-1:0] ADDR_SAMPLE = 6'h16;

endpackage

// File: rtl/gpio6_pin_sync.sv
module gpio6_pin_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio6_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= din;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio6_owner_map.sv
module gpio6_owner_map
   import gpio6_pkg::*;
#(
   parameter int unsigned PINS      = 6,
   parameter int unsigned CLK_PIN_A = 3,
   parameter int unsigned CLK_PIN_B = 4,
   parameter int unsigned RST_PIN   = 5
) (
   input  logic            cfg_ext_reset,
   input  logic [2:0]      cfg_clk_sel,
   output logic [PINS-1:0] taken
);

   generate
      if (CLK_PIN_A >= PINS || CLK_PIN_B >= PINS || RST_PIN >= PINS) begin : g_bad_pin
         $error("gpio6_owner_map: function pin outside the port");
      end
   endgenerate

   logic take_a;
   logic take_b;

   always_comb begin
      unique case (clk_opt_e'(cfg_clk_sel))
         CK_INT_RC:             begin take_a = 1'b0; take_b = 1'b0; end
         CK_EXT_RC, CK_EXT_CLK: begin take_a = 1'b1; take_b = 1'b0; end
         default:               begin take_a = 1'b1; take_b = 1'b1; end
      endcase
   end

   always_comb begin
      taken            = '0;
      taken[CLK_PIN_A] = take_a;
      taken[CLK_PIN_B] = take_b;
      taken[RST_PIN]   = cfg_ext_reset;
   end

endmodule

// File: rtl/gpio6_ctrl_regs.sv
module gpio6_ctrl_regs #(
   parameter int unsigned               BITS     = 5,
   parameter int unsigned               ADDR_W   = 6,
   parameter int unsigned               DATA_W   = 8,
   parameter logic [ADDR_W-1:0]         OUT_ADDR = 6'h18,
   parameter logic [ADDR_W-1:0]         DIR_ADDR = 6'h17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [BITS-1:0]   out_val,
   output logic [BITS-1:0]   dir_val
);

   generate
      if (BITS > DATA_W) begin : g_bad_bits
         $error("gpio6_ctrl_regs: BITS wider than the data bus");
      end
      if (OUT_ADDR == DIR_ADDR) begin : g_bad_addr
         $error("gpio6_ctrl_regs: register addresses collide");
      end
   endgenerate

   wire wr_out = bus_we && (bus_addr == OUT_ADDR);
   wire wr_dir = bus_we && (bus_addr == DIR_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_val <= '0;
         dir_val <= '0;
      end else begin
         if (wr_out) out_val <= bus_wdata[BITS-1:0];
         if (wr_dir) dir_val <= bus_wdata[BITS-1:0];
      end
   end

endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
   import gpio6_pkg::*;
#(
   parameter int unsigned ADDR_W      = PORT_ADDR_W,
   parameter int unsigned DATA_W      = PORT_DATA_W,
   parameter int unsigned PINS        = PORT_PINS,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ext_reset,
   input  logic [2:0]        cfg_clk_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   pad_pullup
);

   localparam int unsigned BIDIR = PINS - 1;
   localparam int unsigned OD_PIN = PINS - 1;

   generate
      if (PINS < 2 || PINS > DATA_W) begin : g_bad_pins
         $error("gpio6_port: PINS must fit the data bus");
      end
   endgenerate

   logic [BIDIR-1:0] out_val;
   logic [BIDIR-1:0] dir_val;
   logic [PINS-1:0]  taken;
   logic [PINS-1:0]  pin_sync;
   logic [DATA_W-1:0] unused_wdata;

   assign unused_wdata = bus_wdata;

   gpio6_ctrl_regs #(
      .BITS(BIDIR), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .OUT_ADDR(ADDR_OUTVAL), .DIR_ADDR(ADDR_DIR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .out_val(out_val), .dir_val(dir_val)
   );

   gpio6_owner_map #(.PINS(PINS), .CLK_PIN_A(3), .CLK_PIN_B(4), .RST_PIN(OD_PIN)) u_owner (
      .cfg_ext_reset(cfg_ext_reset), .cfg_clk_sel(cfg_clk_sel), .taken(taken)
   );

   gpio6_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
   );

   genvar gi;
   generate
      for (gi = 0; gi < PINS; gi++) begin : g_pad
         if (gi < BIDIR) begin : g_bidir
            wire owned = rst_n & ~taken[gi];
            assign pad_oe[gi]     = owned & dir_val[gi];
            assign pad_out[gi]    = owned & dir_val[gi] & out_val[gi];
            assign pad_pullup[gi] = owned & ~dir_val[gi] & out_val[gi];
         end else begin : g_open_drain
            assign pad_oe[gi]     = 1'b0;
            assign pad_out[gi]    = 1'b0;
            assign pad_pullup[gi] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_OUTVAL: bus_rdata[BIDIR-1:0] = out_val;
         ADDR_DIR:    bus_rdata[BIDIR-1:0] = dir_val;
         ADDR_SAMPLE: bus_rdata[PINS-1:0]  = pin_sync & ~taken;
         default:     bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk
   import gpio6_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_ext_reset,
   input logic [2:0] cfg_clk_sel,
   input logic [5:0] bus_addr,
   input logic [7:0] bus_wdata,
   input logic       bus_we,
   input logic [7:0] bus_rdata,
   input logic [5:0] pad_out,
   input logic [5:0] pad_oe,
   input logic [5:0] pad_pullup
);

   always_comb begin
      if (rst_n == 1'b0) begin
         a_r4_async_release: assert (pad_oe == 6'b0 && pad_pullup == 6'b0);
      end
   end

   a_r2_no_drive_and_pull: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pullup) == 6'b0);

   a_r3_pin5_passive: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[5] && !pad_out[5] && !pad_pullup[5]);

   a_r8_crystal_pins_free: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clk_sel >= 3'd3) |-> (pad_oe[4:3] == 2'b0 && pad_pullup[4:3] == 2'b0));

   a_r6_reset_pin_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ext_reset && bus_addr == ADDR_SAMPLE) |-> !bus_rdata[5]);

   a_r1_outval_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_OUTVAL) |=>
         (bus_addr != ADDR_OUTVAL || bus_rdata == {3'b0, $past(bus_wdata[4:0])}));

endmodule

bind gpio6_port gpio6_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_ext_reset(cfg_ext_reset), .cfg_clk_sel(cfg_clk_sel),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
   .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup)
);

// File: tb/gpio6_port_test.sv
`timescale 1ns/1ps
module gpio6_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_ext_reset = 1'b0;
   logic [2:0] cfg_clk_sel = 3'd0;
   logic [5:0] bus_addr = 6'h0;
   logic [7:0] bus_wdata = 8'h0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic [5:0] pad_in = 6'h0;
   logic [5:0] pad_out, pad_oe, pad_pullup;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [5:0] q_addr [$];
   logic [7:0] q_exp  [$];
   string      q_req  [$];

   always #5 clk = ~clk;

   gpio6_port uut (
      .clk(clk), .rst_n(rst_n), .cfg_ext_reset(cfg_ext_reset), .cfg_clk_sel(cfg_clk_sel),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: samples read data 2 ns after the rising edge
   always @(posedge clk) begin
      if (q_addr.size() > 0) begin
         #2;
         check(q_req[0], bus_rdata, q_exp[0]);
         void'(q_addr.pop_front());
         void'(q_exp.pop_front());
         void'(q_req.pop_front());
      end
   end

   task automatic expect_read(input logic [5:0] a, input logic [7:0] e, input string req);
      @(negedge clk);
      bus_addr = a;
      q_addr.push_back(a);
      q_exp.push_back(e);
      q_req.push_back(req);
      wait (q_addr.size() == 0);
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic check_pads(input string req, input logic [5:0] oe, input logic [5:0] out,
                             input logic [5:0] pu);
      @(negedge clk);
      #1;
      check({req, " oe"}, {2'b0, pad_oe}, {2'b0, oe});
      check({req, " out"}, {2'b0, pad_out}, {2'b0, out});
      check({req, " pullup"}, {2'b0, pad_pullup}, {2'b0, pu});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #2;
      // R4: pads released while reset is held
      check("R4 reset oe", {2'b0, pad_oe}, 8'h00);
      check("R4 reset pullup", {2'b0, pad_pullup}, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R5: registers clear on reset
      expect_read(6'h18, 8'h00, "R5 outval reset");
      expect_read(6'h17, 8'h00, "R5 dir reset");

      // R1: readback, upper bits ignored, unmapped address
      bus_write(6'h18, 8'h15);
      expect_read(6'h18, 8'h15, "R1 outval readback");
      bus_write(6'h18, 8'hFF);
      expect_read(6'h18, 8'h1F, "R1 outval upper bits");
      bus_write(6'h17, 8'hEA);
      expect_read(6'h17, 8'h0A, "R1 dir upper bits");
      expect_read(6'h15, 8'h00, "R1 unmapped address");

      // R2, R3: mixed directions, internal RC
      bus_write(6'h17, 8'h0F);
      bus_write(6'h18, 8'h1A);
      check_pads("R2 mixed", 6'h0F, 6'h0A, 6'h10);
      bus_write(6'h17, 8'h00);
      bus_write(6'h18, 8'h1F);
      check_pads("R3 all inputs pulled", 6'h00, 6'h00, 6'h1F);

      // R9: synchronizer latency (pad_in was 0 since reset)
      @(negedge clk);
      pad_in = 6'h2A;
      bus_addr = 6'h16;
      q_addr.push_back(6'h16); q_exp.push_back(8'h00); q_req.push_back("R9 after first edge");
      wait (q_addr.size() == 0);
      expect_read(6'h16, 8'h2A, "R9 after second edge");

      // R7, R8: ownership with every pin driven high
      pad_in = 6'h3F;
      bus_write(6'h17, 8'h1F);
      check_pads("R7 internal RC", 6'h1F, 6'h1F, 6'h00);
      expect_read(6'h16, 8'h3F, "R7 internal RC read");
      cfg_clk_sel = 3'd3;
      check_pads("R8 crystal", 6'h07, 6'h07, 6'h00);
      expect_read(6'h16, 8'h27, "R8 crystal read");
      cfg_clk_sel = 3'd1;
      check_pads("R7 ext RC", 6'h17, 6'h17, 6'h00);
      cfg_clk_sel = 3'd2;
      expect_read(6'h16, 8'h37, "R7 ext clock read");
      cfg_clk_sel = 3'd5;
      check_pads("R7 resonator", 6'h07, 6'h07, 6'h00);
      cfg_clk_sel = 3'd7;
      check_pads("R7 reserved code", 6'h07, 6'h07, 6'h00);
      bus_write(6'h17, 8'h00);
      cfg_clk_sel = 3'd4;
      check_pads("R8 low-freq crystal pullups", 6'h00, 6'h00, 6'h07);

      // R6: pin 5 as external reset
      cfg_clk_sel = 3'd0;
      cfg_ext_reset = 1'b1;
      expect_read(6'h16, 8'h1F, "R6 reset pin reads 0");
      cfg_ext_reset = 1'b0;
      expect_read(6'h16, 8'h3F, "R6 pin 5 port input");

      // R4: asynchronous release between clock edges
      bus_write(6'h17, 8'h1F);
      @(negedge clk);
      #1 rst_n = 1'b0;
      #1;
      check("R4 async oe", {2'b0, pad_oe}, 8'h00);
      check("R4 async pullup", {2'b0, pad_pullup}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      expect_read(6'h17, 8'h00, "R5 dir cleared by second reset");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule